// File: doc/BRIEF.md
# Time-Interleaved Converter Bank Scheduler

This controller makes an array of slow cyclic converters act as a single faster converter. The converters are arranged as banks, each holding one converter per lane of a shared sampling bus. A single base clock runs at the output word rate. Every fourth base cycle, an enable marks the end of one converter period. In each converter period exactly one bank is selected to capture the bus. The select rotates one bank per period. A one-hot column-group register picks which group of sensor columns drives the bus during that period.

A conversion lasts as many converter periods as there are banks. Each bank therefore finishes its previous conversion just as its turn to sample comes round again. During that period the readout stage drains the finished bank's results, one lane per base cycle, lane A first and lane D last. Each word carries a valid flag and a channel tag. The converters are stubs: each holds the captured bus word as its result and only reports done after the full conversion latency. The bus input is a digital stand-in for the analog lines.

Top module: `tiadc_sched`

## Requirements
- R1: `bank_sel` is one-hot at all times. Reset and `frame_start` place it on bit 0 (bank 1).
- R2: `bank_sel` moves only on a base-clock edge where `adc_en` is high. It moves one bit up, and from the top bit it wraps back to bit 0.
- R3: `adc_en` is high for one base cycle out of every four. After reset or `frame_start` it is first high in the fourth cycle.
- R4: `grp_sel` is one-hot with NGROUPS bits. It advances one bit on each `adc_en` edge and wraps after the last group.
- R5: The converters of a bank capture `bus_in` only on an edge where `adc_en` is high and that bank is selected. `bus_in` values present on all other edges never reach the output.
- R6: Lane c of the bus occupies bits [8c+7:8c]. The word read out for lane c of a bank equals the lane-c value that bank captured exactly NBANK converter periods earlier.
- R7: In converter period m (counted from 0 after reset or frame start), base cycle c of that period drives the output. One cycle later the output holds bank m mod NBANK, lane c. Lanes are emitted in the order A, B, C, D, and banks in rotation order.
- R8: `out_vld` stays low until a bank has finished a full conversion. It is therefore first high in period NBANK after reset or `frame_start`, and high on every word from then on.
- R9: `frame_start` is synchronous. On its edge it returns the phase, the bank select and the group select to their start, and clears all completion state and `out_vld`, whatever phase it arrives in.
- R10: `out_tag` is {bank index 0..NBANK-1 in the upper 3 bits, lane index 0..3 for A..D in the lower 2 bits}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock at the output word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Synchronous restart of the schedule |
| bus_in | input | NCONV*DW | Shared sampling bus, one DW-bit word per lane |
| bank_sel | output | NBANK | One-hot sampling select, one bit per bank |
| grp_sel | output | NGROUPS | One-hot column group driving the bus |
| adc_en | output | 1 | Converter-period enable, one base cycle in four |
| out_vld | output | 1 | Output word is a finished result |
| out_tag | output | BW+CW | Bank and lane of the output word |
| out_data | output | DW | Result word |

## Verification
Several properties are checked on every cycle. The select and group registers must stay one-hot, move only on the period enable, and rotate by exactly one bit. The enable must keep its one-in-four spacing. Tag lanes must step A to D, frame start must return everything home, and valid must stay low until a full rotation of periods has passed. Only the bench's scenarios can show that each word equals the exact lane value captured one rotation earlier. The same goes for junk driven on non-sampling edges never appearing, and for a restart arriving mid-period correctly re-basing the whole schedule.

// File: rtl/tiadc_pkg.sv
`timescale 1ns/1ps
package tiadc_pkg;

  // Index of the set bit in a one-hot word (lowest set bit wins).
  function automatic logic [5:0] oh_index(input logic [63:0] oh);
    logic [5:0] idx;
    idx = '0;
    for (int i = 63; i >= 0; i--) begin
      if (oh[i]) idx = 6'(i);
    end
    return idx;
  endfunction

  // Width helper that never returns zero.
  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tiadc_phase.sv
`timescale 1ns/1ps
module tiadc_phase #(
  parameter int NCONV = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] ph,
  output logic          adc_en
);
  localparam logic [CW-1:0] LAST = CW'(NCONV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph <= '0;
    else if (clr)        ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + 1'b1;
  end

  assign adc_en = (ph == LAST);
endmodule

// File: rtl/tiadc_ring.sv
`timescale 1ns/1ps
module tiadc_ring #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] HOME = W'(1);
  logic [W-1:0] q_nxt;

  generate
    if (W > 1) begin : g_rot
      assign q_nxt = {q[W-2:0], q[W-1]};
    end else begin : g_one
      assign q_nxt = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= HOME;
    else if (clr) q <= HOME;
    else if (adv) q <= q_nxt;
  end
endmodule

// File: rtl/tiadc_conv_stub.sv
`timescale 1ns/1ps
module tiadc_conv_stub #(
  parameter int DW  = 8,
  parameter int LAT = 8,
  parameter int LW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic          tick,
  input  logic [DW-1:0] din,
  output logic          done,
  output logic [DW-1:0] dout
);
  logic [LW-1:0] left_q;
  logic          loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      loaded_q <= 1'b0;
      dout     <= '0;
    end else if (clr) begin
      left_q   <= '0;
      loaded_q <= 1'b0;
    end else if (cap) begin
      left_q   <= LW'(LAT - 1);
      loaded_q <= 1'b1;
      dout     <= din;
    end else if (tick && left_q != '0) begin
      left_q   <= left_q - 1'b1;
    end
  end

  assign done = loaded_q && (left_q == '0);
endmodule

// File: rtl/tiadc_readout.sv
`timescale 1ns/1ps
module tiadc_readout #(
  parameter int NBANK = 8,
  parameter int NCONV = 4,
  parameter int DW    = 8,
  parameter int BW    = 3,
  parameter int CW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [BW-1:0]             bank_idx,
  input  logic [CW-1:0]             ph,
  input  logic [NBANK*NCONV-1:0]    done_vec,
  input  logic [NBANK*NCONV*DW-1:0] res_vec,
  output logic                      rd_done,
  output logic                      out_vld,
  output logic [BW+CW-1:0]          out_tag,
  output logic [DW-1:0]             out_data
);
  logic [BW+CW-1:0] sel;
  logic [DW-1:0]    rd_word;

  assign sel     = {bank_idx, ph};
  assign rd_done = done_vec[sel];
  assign rd_word = res_vec[int'(sel)*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_tag  <= '0;
      out_data <= '0;
    end else if (clr) begin
      out_vld  <= 1'b0;
    end else begin
      out_vld  <= rd_done;
      out_tag  <= sel;
      out_data <= rd_word;
    end
  end
endmodule

// File: rtl/tiadc_sched.sv
`timescale 1ns/1ps
module tiadc_sched
  import tiadc_pkg::*;
#(
  parameter int NBANK   = 8,
  parameter int NCONV   = 4,
  parameter int DW      = 8,
  parameter int NGROUPS = 32,
  localparam int BW = safe_clog2(NBANK),
  localparam int CW = safe_clog2(NCONV),
  localparam int TW = BW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [NCONV*DW-1:0] bus_in,
  output logic [NBANK-1:0]    bank_sel,
  output logic [NGROUPS-1:0]  grp_sel,
  output logic                adc_en,
  output logic                out_vld,
  output logic [TW-1:0]       out_tag,
  output logic [DW-1:0]       out_data
);
  localparam int LAT = NBANK;
  localparam int LW  = safe_clog2(LAT);

  logic [CW-1:0]             ph;
  logic [BW-1:0]             bank_idx;
  logic [NBANK*NCONV-1:0]    done_vec;
  logic [NBANK*NCONV*DW-1:0] res_vec;
  logic                      rd_done;
  logic                      bank_wrap;

  tiadc_phase #(.NCONV(NCONV), .CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .ph(ph), .adc_en(adc_en)
  );

  tiadc_ring #(.W(NBANK)) u_bank_ring (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .adv(adc_en), .q(bank_sel)
  );

  tiadc_ring #(.W(NGROUPS)) u_grp_ring (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .adv(adc_en), .q(grp_sel)
  );

  assign bank_idx  = BW'(oh_index(64'(bank_sel)));
  assign bank_wrap = adc_en && bank_sel[NBANK-1];

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      for (genvar c = 0; c < NCONV; c++) begin : g_lane
        tiadc_conv_stub #(.DW(DW), .LAT(LAT), .LW(LW)) u_conv (
          .clk  (clk),
          .rst_n(rst_n),
          .clr  (frame_start),
          .cap  (adc_en && bank_sel[b]),
          .tick (adc_en),
          .din  (bus_in[c*DW +: DW]),
          .done (done_vec[b*NCONV + c]),
          .dout (res_vec[(b*NCONV + c)*DW +: DW])
        );
      end
    end
  endgenerate

  tiadc_readout #(.NBANK(NBANK), .NCONV(NCONV), .DW(DW), .BW(BW), .CW(CW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(frame_start),
    .bank_idx(bank_idx), .ph(ph), .done_vec(done_vec), .res_vec(res_vec),
    .rd_done(rd_done), .out_vld(out_vld), .out_tag(out_tag), .out_data(out_data)
  );
endmodule

// File: rtl/tiadc_sched_chk.sv
`timescale 1ns/1ps
module tiadc_sched_chk #(
  parameter int NBANK   = 8,
  parameter int NCONV   = 4,
  parameter int NGROUPS = 32,
  parameter int TW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [NBANK-1:0]   bank_sel,
  input logic [NGROUPS-1:0] grp_sel,
  input logic               adc_en,
  input logic               out_vld,
  input logic [TW-1:0]      out_tag,
  input logic               bank_wrap,
  input logic               rd_done
);
  localparam int GW = $clog2(NCONV + 1);
  localparam int PW = $clog2(NBANK + 1);

  logic [GW-1:0] gap_q;
  logic [PW-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      per_q <= '0;
    end else if (frame_start) begin
      gap_q <= '0;
      per_q <= '0;
    end else begin
      gap_q <= adc_en ? '0 : gap_q + 1'b1;
      if (adc_en && per_q != PW'(NBANK)) per_q <= per_q + 1'b1;
    end
  end

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_sel) == 1);

  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_en && !frame_start) |=> $stable(bank_sel));

  a_r2_sel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && !frame_start) |=>
      bank_sel == {$past(bank_sel[NBANK-2:0]), $past(bank_sel[NBANK-1])});

  a_r2_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wrap && !frame_start) |=> bank_sel[0]);

  a_r3_en_gap: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |=> !adc_en);

  a_r3_en_period: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> gap_q == GW'(NCONV - 1));

  a_r4_grp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_sel) == 1);

  a_r4_grp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && !frame_start) |=>
      grp_sel == {$past(grp_sel[NGROUPS-2:0]), $past(grp_sel[NGROUPS-1])});

  a_r7_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !frame_start) |=> (!out_vld || out_tag[1:0] == $past(out_tag[1:0]) + 2'd1));

  a_r8_vld_wait: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> per_q == PW'(NBANK));

  a_r8_done_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> per_q == PW'(NBANK));

  a_r9_fs_home: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bank_sel == NBANK'(1) && grp_sel == NGROUPS'(1) && !adc_en && !out_vld));
endmodule

bind tiadc_sched tiadc_sched_chk #(
  .NBANK(NBANK), .NCONV(NCONV), .NGROUPS(NGROUPS), .TW(TW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bank_sel(bank_sel),
  .grp_sel(grp_sel), .adc_en(adc_en), .out_vld(out_vld), .out_tag(out_tag),
  .bank_wrap(bank_wrap), .rd_done(rd_done)
);

// File: tb/tiadc_sched_tb.sv
`timescale 1ns/1ps
module tiadc_sched_tb_top;
  localparam int NBANK   = 8;
  localparam int NCONV   = 4;
  localparam int DW      = 8;
  localparam int NGROUPS = 6;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                frame_start;
  logic [NCONV*DW-1:0] bus_in;
  logic [NBANK-1:0]    bank_sel;
  logic [NGROUPS-1:0]  grp_sel;
  logic                adc_en;
  logic                out_vld;
  logic [4:0]          out_tag;
  logic [DW-1:0]       out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // Stimulus seeds per converter period; lane value mixes in the lane number.
  localparam logic [7:0] SEED [16] = '{
    8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hC3,
    8'h7E, 8'h12, 8'h34, 8'h56, 8'h9B, 8'hE7, 8'h0F, 8'hF0};

  always #5 clk = ~clk;

  tiadc_sched #(.NBANK(NBANK), .NCONV(NCONV), .DW(DW), .NGROUPS(NGROUPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bus_in(bus_in),
    .bank_sel(bank_sel), .grp_sel(grp_sel), .adc_en(adc_en),
    .out_vld(out_vld), .out_tag(out_tag), .out_data(out_data)
  );

  function automatic logic [7:0] pat(input int n, input int c);
    return SEED[n % 16] ^ 8'(c * 8'h3B);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs num edges from a fresh schedule (after reset or frame start).
  task automatic run_edges(input int num, input int base);
    for (int e = 0; e < num; e++) begin
      // R5: real data only on the sampling edge, junk elsewhere
      for (int c = 0; c < NCONV; c++)
        bus_in[c*DW +: DW] = (e % 4 == 3) ? pat(e / 4 + base, c) : ~pat(e / 4 + base + 7, c);
      @(posedge clk);
      @(negedge clk);
      begin
        int na = (e + 1) / 4;
        int pa = (e + 1) % 4;
        int m  = e / 4;
        int c  = e % 4;
        check("R1/R2 bank_sel", 64'(bank_sel), 64'(NBANK'(1) << (na % NBANK)));
        check("R4 grp_sel", 64'(grp_sel), 64'(NGROUPS'(1) << (na % NGROUPS)));
        check("R3 adc_en", 64'(adc_en), 64'(pa == 3));
        check("R8 out_vld", 64'(out_vld), 64'(m >= NBANK));
        check("R7/R10 out_tag", 64'(out_tag), 64'({3'(m % NBANK), 2'(c)}));
        if (m >= NBANK)
          check("R6/R5 out_data", 64'(out_data), 64'(pat(m - NBANK + base, c)));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; bus_in = '0;
    repeat (3) @(negedge clk);
    // Reset state (R1, R3, R4, R8)
    check("R1 reset bank_sel", 64'(bank_sel), 64'd1);
    check("R4 reset grp_sel", 64'(grp_sel), 64'd1);
    check("R3 reset adc_en", 64'(adc_en), 64'd0);
    check("R8 reset out_vld", 64'(out_vld), 64'd0);
    rst_n = 1'b1;
    // Main run, ending mid-period
    run_edges(4 * 30 + 2, 0);
    // R9: frame start arriving mid-period
    frame_start = 1'b1;
    bus_in = '1;
    @(posedge clk);
    @(negedge clk);
    frame_start = 1'b0;
    check("R9 home bank_sel", 64'(bank_sel), 64'd1);
    check("R9 home grp_sel", 64'(grp_sel), 64'd1);
    check("R9 home adc_en", 64'(adc_en), 64'd0);
    check("R9 cleared out_vld", 64'(out_vld), 64'd0);
    run_edges(4 * 20, 5);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule